// File: doc/BRIEF.md
# PHY Test-Port Configuration Register Programmer

This block is the slave end of a slow serial test-control port on a physical-layer macro. The port has four wires: a test clock, a test enable, an 8-bit input byte and a clear line. A controller first presents a code byte and drops the test clock while test enable is high. That code becomes the current address. It then lowers test enable, presents a data byte and raises the test clock, which writes the byte into the register at that address. The block only holds the values. It shows them on decoded field outputs and on an 8-bit read-back bus that always reflects the register at the latched address.

The test clock is asynchronous to the block clock. It passes through a synchronizer chain before any edge detection. The controller must hold test enable and the input byte steady from its own clock transition until the block has seen the edge, which takes a few block-clock cycles. Two addresses are split registers. Bit 7 of the data byte chooses which sub-field a write lands in, so one address takes two successive writes that target different sub-fields.

Top module: `tport_prog`

## Requirements
- R1: After reset the latched code is 0x00, every register and field output is zero, and the read-back bus reads zero.
- R2: A falling test-clock edge with test enable high latches the input byte as the code. A rising edge with test enable high writes nothing.
- R3: A rising test-clock edge with test enable low writes the input byte to the register at the latched code. A falling edge with test enable low leaves the code unchanged.
- R4: The read-back bus always shows the content of the register at the latched code.
- R5: A write to any code other than the implemented ones is ignored, and the read-back bus reads 0x00 while such a code is latched.
- R6: Code 0x18 holds a 10-bit loop divider value (divider minus 1). When data bit 7 is 0, bits 4:0 go to the low five bits. When bit 7 is 1, bits 4:0 go to the high five bits. The other half is kept. Read-back is {bit 7 of the last write, 2'b00, the half that write selected}.
- R7: Code 0x22 is split on data bit 7. When bit 7 is 0, bits 2:0 go to the 3-bit bias-resistor field. When bit 7 is 1, bits 2:0 go to the 3-bit bandgap field. Read-back is {bit 7 of the last write, 4'b0000, the selected field}.
- R8: Code 0x17 stores data bits 6:0 as the 7-bit input divider (ratio minus 1). Read-back bit 7 is 0.
- R9: Code 0x44 stores data bits 6:1 as the 6-bit frequency-range field. Read-back is {1'b0, field, 1'b0}.
- R10: While test clear is high, the code and all registers return to zero on each block clock, and test-clock edges have no effect.
- R11: Codes 0x10, 0x11, 0x12, 0x19, 0x20, 0x21, 0x70, 0x71 and 0x72 are plain 8-bit registers that store and read back the full byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tclk_i | input | 1 | Test clock, asynchronous |
| ten_i | input | 1 | Test enable: high for code, low for data |
| tclr_i | input | 1 | Test clear, active high |
| tdin_i | input | 8 | Test input byte |
| dout_o | output | 8 | Read-back of the register at the latched code |
| code_o | output | 8 | Currently latched code |
| loop_div_o | output | 10 | Loop divider value |
| in_div_o | output | 7 | Input divider value |
| freq_range_o | output | 6 | Frequency-range field |
| bias_res_o | output | 3 | Bias-resistor select |
| bandgap_o | output | 3 | Bandgap select |

## Verification
The bench sweeps every value of each narrow field:
- all 32 values into each loop-divider half, with junk in the unused bits, which separates the two halves and shows the kept half survives;
- all 8 values into both bias sub-fields;
- all 128 input-divider values with bit 7 forced high;
- all 256 bytes into the frequency-range code, which exposes any shift or mask error.

Each plain register gets several bytes. Afterwards all plain registers are re-selected without writing, which separates address decoding from aliasing between neighbours. Edges with the wrong enable level, writes to unimplemented codes and writes issued under clear are each followed by read-back checks. These confirm that nothing moved.

// File: rtl/tport_pkg.sv
`timescale 1ns/1ps
package tport_pkg;
  localparam int DW        = 8;
  localparam int PHASE_BIT = 7;
  localparam int LD_HALF   = 5;
  localparam int LD_W      = 2 * LD_HALF;
  localparam int IDIV_W    = 7;
  localparam int FR_W      = 6;
  localparam int FR_LSB    = 1;
  localparam int BIAS_W    = 3;
  localparam int NPLAIN    = 9;

  localparam logic [DW-1:0] C_LOOPDIV = 8'h18;
  localparam logic [DW-1:0] C_BIAS    = 8'h22;
  localparam logic [DW-1:0] C_INDIV   = 8'h17;
  localparam logic [DW-1:0] C_FRANGE  = 8'h44;

  localparam logic [NPLAIN*DW-1:0] PLAIN_CODES =
    {8'h72, 8'h71, 8'h70, 8'h21, 8'h20, 8'h19, 8'h12, 8'h11, 8'h10};

  function automatic logic [DW-1:0] plain_code(input int i);
    return PLAIN_CODES[i*DW +: DW];
  endfunction

  function automatic logic is_plain(input logic [DW-1:0] c);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < NPLAIN; i++) if (c == plain_code(i)) hit = 1'b1;
    return hit;
  endfunction

  function automatic logic is_impl(input logic [DW-1:0] c);
    return is_plain(c) || c == C_LOOPDIV || c == C_BIAS ||
           c == C_INDIV || c == C_FRANGE;
  endfunction
endpackage

// File: rtl/tport_edge_det.sv
`timescale 1ns/1ps
module tport_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  // q[STAGES-1] is the synchronized level, q[STAGES] its previous value
  logic [STAGES:0] q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q <= '0;
    else         q <= {q[STAGES-1:0], d_i};

  assign rise_o =  q[STAGES-1] & ~q[STAGES];
  assign fall_o = ~q[STAGES-1] &  q[STAGES];
endmodule

// File: rtl/tport_code_latch.sv
`timescale 1ns/1ps
module tport_code_latch import tport_pkg::*; (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          cap_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] code_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    code_o <= '0;
    else if (clr_i) code_o <= '0;
    else if (cap_i) code_o <= d_i;
endmodule

// File: rtl/tport_regfile.sv
`timescale 1ns/1ps
module tport_regfile import tport_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [DW-1:0]     code_i,
  input  logic [DW-1:0]     data_i,
  output logic [DW-1:0]     rd_o,
  output logic [LD_W-1:0]   loop_div_o,
  output logic [IDIV_W-1:0] in_div_o,
  output logic [FR_W-1:0]   freq_range_o,
  output logic [BIAS_W-1:0] bias_res_o,
  output logic [BIAS_W-1:0] bandgap_o
);
  logic [NPLAIN*DW-1:0] plain_flat;

  for (genvar g = 0; g < NPLAIN; g++) begin : g_plain
    logic [DW-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)    r_q <= '0;
      else if (clr_i) r_q <= '0;
      else if (we_i && code_i == plain_code(g)) r_q <= data_i;
    assign plain_flat[g*DW +: DW] = r_q;
  end

  logic [LD_HALF-1:0] ld_lo_q, ld_hi_q;
  logic               ld_ph_q;
  logic [BIAS_W-1:0]  bres_q, bgap_q;
  logic               b_ph_q;
  logic [IDIV_W-1:0]  idiv_q;
  logic [FR_W-1:0]    fr_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      ld_lo_q <= '0; ld_hi_q <= '0; ld_ph_q <= 1'b0;
    end else if (clr_i) begin
      ld_lo_q <= '0; ld_hi_q <= '0; ld_ph_q <= 1'b0;
    end else if (we_i && code_i == C_LOOPDIV) begin
      ld_ph_q <= data_i[PHASE_BIT];
      if (data_i[PHASE_BIT]) ld_hi_q <= data_i[LD_HALF-1:0];
      else                   ld_lo_q <= data_i[LD_HALF-1:0];
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      bres_q <= '0; bgap_q <= '0; b_ph_q <= 1'b0;
    end else if (clr_i) begin
      bres_q <= '0; bgap_q <= '0; b_ph_q <= 1'b0;
    end else if (we_i && code_i == C_BIAS) begin
      b_ph_q <= data_i[PHASE_BIT];
      if (data_i[PHASE_BIT]) bgap_q <= data_i[BIAS_W-1:0];
      else                   bres_q <= data_i[BIAS_W-1:0];
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    idiv_q <= '0;
    else if (clr_i) idiv_q <= '0;
    else if (we_i && code_i == C_INDIV) idiv_q <= data_i[IDIV_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    fr_q <= '0;
    else if (clr_i) fr_q <= '0;
    else if (we_i && code_i == C_FRANGE) fr_q <= data_i[FR_LSB +: FR_W];

  always_comb begin
    rd_o = '0;
    for (int i = 0; i < NPLAIN; i++)
      if (code_i == plain_code(i)) rd_o = plain_flat[i*DW +: DW];
    unique case (code_i)
      C_LOOPDIV: rd_o = {ld_ph_q, {(DW-1-LD_HALF){1'b0}}, ld_ph_q ? ld_hi_q : ld_lo_q};
      C_BIAS:    rd_o = {b_ph_q, {(DW-1-BIAS_W){1'b0}}, b_ph_q ? bgap_q : bres_q};
      C_INDIV:   rd_o = {{(DW-IDIV_W){1'b0}}, idiv_q};
      C_FRANGE:  rd_o = {{(DW-FR_W-FR_LSB){1'b0}}, fr_q, {FR_LSB{1'b0}}};
      default:   ;
    endcase
  end

  assign loop_div_o   = {ld_hi_q, ld_lo_q};
  assign in_div_o     = idiv_q;
  assign freq_range_o = fr_q;
  assign bias_res_o   = bres_q;
  assign bandgap_o    = bgap_q;
endmodule

// File: rtl/tport_prog.sv
`timescale 1ns/1ps
module tport_prog import tport_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tclk_i,
  input  logic              ten_i,
  input  logic              tclr_i,
  input  logic [DW-1:0]     tdin_i,
  output logic [DW-1:0]     dout_o,
  output logic [DW-1:0]     code_o,
  output logic [LD_W-1:0]   loop_div_o,
  output logic [IDIV_W-1:0] in_div_o,
  output logic [FR_W-1:0]   freq_range_o,
  output logic [BIAS_W-1:0] bias_res_o,
  output logic [BIAS_W-1:0] bandgap_o
);
  logic rise_w, fall_w;

  tport_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(tclk_i),
    .rise_o(rise_w), .fall_o(fall_w)
  );

  // ten_i and tdin_i are held steady by the controller across the sync delay
  tport_code_latch u_code (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(tclr_i),
    .cap_i (fall_w & ten_i), .d_i(tdin_i), .code_o(code_o)
  );

  tport_regfile u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (tclr_i),
    .we_i        (rise_w & ~ten_i),
    .code_i      (code_o),
    .data_i      (tdin_i),
    .rd_o        (dout_o),
    .loop_div_o  (loop_div_o),
    .in_div_o    (in_div_o),
    .freq_range_o(freq_range_o),
    .bias_res_o  (bias_res_o),
    .bandgap_o   (bandgap_o)
  );
endmodule

// File: rtl/tport_prog_chk.sv
`timescale 1ns/1ps
module tport_prog_chk import tport_pkg::*; (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            tclr_i,
  input logic            ten_i,
  input logic [DW-1:0]   tdin_i,
  input logic [DW-1:0]   code_o,
  input logic [DW-1:0]   dout_o,
  input logic [LD_W-1:0] loop_div_o,
  input logic            rise_w,
  input logic            fall_w
);
  p_code_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tclr_i && fall_w && ten_i) |=> code_o == $past(tdin_i));

  p_code_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tclr_i && !(fall_w && ten_i)) |=> $stable(code_o));

  p_unimpl_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_impl(code_o) |-> dout_o == '0);

  p_ldiv_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tclr_i && !(rise_w && !ten_i && code_o == C_LOOPDIV)) |=> $stable(loop_div_o));

  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tclr_i |=> (code_o == '0 && dout_o == '0 && loop_div_o == '0));
endmodule

bind tport_prog tport_prog_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tclr_i(tclr_i), .ten_i(ten_i),
  .tdin_i(tdin_i), .code_o(code_o), .dout_o(dout_o),
  .loop_div_o(loop_div_o), .rise_w(rise_w), .fall_w(fall_w)
);

// File: tb/sim_tport_prog.sv
`timescale 1ns/1ps
module sim_tport_prog;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tclk = 1'b1, ten = 1'b0, tclr = 1'b0;
  logic [7:0] tdin = '0;
  logic [7:0] dout, code;
  logic [9:0] loop_div;
  logic [6:0] in_div;
  logic [5:0] frange;
  logic [2:0] bres, bgap;

  always #2 clk = ~clk;

  tport_prog u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tclk_i(tclk), .ten_i(ten), .tclr_i(tclr),
    .tdin_i(tdin), .dout_o(dout), .code_o(code), .loop_div_o(loop_div),
    .in_div_o(in_div), .freq_range_o(frange), .bias_res_o(bres), .bandgap_o(bgap)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // model state, from the requirements
  logic [7:0] m_code = '0;
  logic [7:0] m_plain [9];
  logic [4:0] m_lo = '0, m_hi = '0;
  logic       m_lph = 1'b0, m_bph = 1'b0;
  logic [2:0] m_bres = '0, m_bgap = '0;
  logic [6:0] m_idiv = '0;
  logic [5:0] m_fr = '0;
  logic [7:0] pcodes [9] = '{8'h10, 8'h11, 8'h12, 8'h19, 8'h20, 8'h21, 8'h70, 8'h71, 8'h72};

  function automatic logic [7:0] exp_rd(input logic [7:0] c);
    logic [7:0] r;
    r = 8'h00;
    for (int i = 0; i < 9; i++) if (c == pcodes[i]) r = m_plain[i];
    case (c)
      8'h18: r = {m_lph, 2'b00, m_lph ? m_hi : m_lo};
      8'h22: r = {m_bph, 4'b0000, m_bph ? m_bgap : m_bres};
      8'h17: r = {1'b0, m_idiv};
      8'h44: r = {1'b0, m_fr, 1'b0};
      default: ;
    endcase
    return r;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " dout"}, {8'h0, dout}, {8'h0, exp_rd(m_code)});
    chk({tag, " code"}, {8'h0, code}, {8'h0, m_code});
    chk({tag, " ldiv"}, {6'h0, loop_div}, {6'h0, m_hi, m_lo});
    chk({tag, " idiv"}, {9'h0, in_div}, {9'h0, m_idiv});
    chk({tag, " frng"}, {10'h0, frange}, {10'h0, m_fr});
    chk({tag, " bias"}, {10'h0, bgap, bres}, {10'h0, m_bgap, m_bres});
  endtask

  task automatic tk(input logic v);
    tclk = v;
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic model_wr(input logic [7:0] c, input logic [7:0] d);
    for (int i = 0; i < 9; i++) if (c == pcodes[i]) m_plain[i] = d;
    case (c)
      8'h18: begin m_lph = d[7]; if (d[7]) m_hi = d[4:0]; else m_lo = d[4:0]; end
      8'h22: begin m_bph = d[7]; if (d[7]) m_bgap = d[2:0]; else m_bres = d[2:0]; end
      8'h17: m_idiv = d[6:0];
      8'h44: m_fr = d[6:1];
      default: ;
    endcase
  endtask

  task automatic wr(input logic [7:0] c, input logic [7:0] d);
    ten = 1'b1; tdin = c; tk(1'b0);
    ten = 1'b0; tdin = d; tk(1'b1);
    m_code = c; model_wr(c, d);
  endtask

  // select a code without writing: rise with enable high (R2)
  task automatic sel(input logic [7:0] c);
    ten = 1'b1; tdin = c; tk(1'b0);
    tdin = ~c; tk(1'b1);
    ten = 1'b0;
    m_code = c;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 9; i++) m_plain[i] = '0;
    repeat (5) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    repeat (8) @(posedge clk); @(negedge clk);
    chk_all("R1 reset");

    // R11 plain registers, several bytes each
    for (int i = 0; i < 9; i++)
      for (int k = 0; k < 4; k++) begin
        wr(pcodes[i], 8'(i * 29 + k * 71 + 3));
        chk_all("R11 plain wr");
      end
    // R4 re-select each plain register; no aliasing
    for (int i = 0; i < 9; i++) begin sel(pcodes[i]); chk_all("R4 reselect"); end

    // R6 loop divider halves, junk in bits 6:5
    for (int v = 0; v < 32; v++) begin
      wr(8'h18, {1'b0, 2'(v), 5'(v)});       chk_all("R6 low half");
      wr(8'h18, {1'b1, 2'(~v), 5'(31 - v)}); chk_all("R6 high half");
    end

    // R7 bias / bandgap
    for (int v = 0; v < 8; v++) begin
      wr(8'h22, {1'b0, 4'hF, 3'(v)});     chk_all("R7 bias res");
      wr(8'h22, {1'b1, 4'h5, 3'(7 - v)}); chk_all("R7 bandgap");
    end

    // R8 input divider, bit 7 forced high
    for (int v = 0; v < 128; v++) begin wr(8'h17, {1'b1, 7'(v)}); chk_all("R8 indiv"); end

    // R9 frequency range, all bytes
    for (int v = 0; v < 256; v++) begin wr(8'h44, 8'(v)); chk_all("R9 frange"); end

    // R5 unimplemented codes
    wr(8'h00, 8'hFF); chk_all("R5 code00");
    wr(8'h13, 8'hA5); chk_all("R5 code13");
    wr(8'h45, 8'h3C); chk_all("R5 code45");
    wr(8'hFF, 8'h77); chk_all("R5 codeFF");
    sel(8'h10); chk_all("R5 neighbour kept");

    // R2 rising edge with enable high does not write
    ten = 1'b1; tdin = 8'h20; tk(1'b0); m_code = 8'h20;
    tdin = 8'hC3; tk(1'b1);
    chk_all("R2 rise with enable high");
    // R3 falling edge with enable low keeps code, then rise writes
    ten = 1'b0; tdin = 8'h71; tk(1'b0);
    chk_all("R3 fall with enable low");
    tdin = 8'h5A; tk(1'b1); model_wr(8'h20, 8'h5A);
    chk_all("R3 write");

    // R10 test clear
    tclr = 1'b1;
    repeat (2) @(posedge clk); @(negedge clk);
    m_code = '0; m_lo = '0; m_hi = '0; m_lph = 0; m_bph = 0; m_bres = '0; m_bgap = '0;
    m_idiv = '0; m_fr = '0;
    for (int i = 0; i < 9; i++) m_plain[i] = '0;
    chk_all("R10 clear");
    ten = 1'b1; tdin = 8'h44; tk(1'b0);
    ten = 1'b0; tdin = 8'hFE; tk(1'b1);
    chk_all("R10 edges ignored");
    tclr = 1'b0;
    repeat (2) @(posedge clk); @(negedge clk);
    sel(8'h44); chk_all("R10 after release");
    sel(8'h20); chk_all("R10 plain cleared");
    wr(8'h70, 8'h99); chk_all("R11 after clear");

    finish_run();
  end
endmodule